// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

A sixteen-pin I/O port that a processor configures and drives through a small single-cycle register bus. Each pin has a 2-bit mode (input, general output, peripheral-driven alternate function, analog), an output stage type (push-pull or open-drain), a bias selection, a stored drive-strength field and a 4-bit alternate-function selector. From this configuration the block produces, for every pin, an output-enable, an output value and pull-up/pull-down controls for the pad ring. For pins in alternate-function mode, the output value comes from a peripheral input instead of the output register.

Pin levels pass through a two-stage synchronizer and are read back through a read-only input register. Output bits can be written as a whole word, or set and cleared per bit in a single atomic write, so software never has to read, modify and write back. A keyed five-access sequence on a lock register freezes the configuration of a chosen set of pins until the next reset. This protects pins whose configuration is critical to safety from being changed by accident.

The selector field is stored only. Routing between peripherals and pins, analog pad circuits and slew-rate drivers sit outside this block.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads 0, and every pin has output-enable, output value, pull-up and pull-down at 0.
- R2: The mode field of pin n is at bits [2n+1:2n] of word 0. Code 01 drives the pin from output-register bit n. Code 10 drives it from `alt_val_i[n]`. Codes 00 (input) and 11 (analog) hold output-enable and output value at 0.
- R3: The type bit of pin n is bit n of word 1. With 0 (push-pull), a driving pin has output-enable 1 and output value equal to the selected value. With 1 (open-drain), a selected value of 0 gives output-enable 1 with output value 0, and a selected value of 1 releases the pin (output-enable 0). An open-drain pin never drives high.
- R4: The bias field of pin n is at bits [2n+1:2n] of word 3. Code 01 raises the pull-up, code 10 raises the pull-down, and codes 00 and 11 raise neither. A pin in analog mode raises no pull.
- R5: A write to word 6 sets output bit n for each 1 in bits [15:0] and clears output bit n for each 1 in bits [31:16]. When both bits of a pin are 1, the set wins. Output bits not named in the write keep their value, and word 6 reads as 0.
- R6: Word 5 is the output register. It is written and read as a whole in bits [15:0].
- R7: Word 4 reads the pin levels in bits [15:0] after a two-flop synchronizer. A pin in analog mode reads 0. Writes to word 4 have no effect.
- R8: Word 2 stores a 2-bit drive-strength field per pin at [2n+1:2n]. Word 8 holds the 4-bit selector of pins 0 to 7 at [4n+3:4n]. Word 9 holds the selectors of pins 8 to 15 in the same layout, starting at pin 8. All of these read back as written.
- R9: Word 7 is the lock register, with the key in bit 16 and a pin mask in bits [15:0]. The lock takes effect after three writes carrying the same mask with keys 1, 0 and 1, followed by two reads. From then on, the mode, type, drive-strength, bias and selector fields of the masked pins ignore writes until reset. Word 7 then reads bit 16 = 1 and bits [15:0] = mask.
- R10: A lock-register access that does not fit the sequence (wrong key, a changed mask, or a read where a write is due) returns the sequence to its start without locking. Accesses to other words in between do not disturb the sequence.
- R11: Once a lock has taken effect, the lock register is frozen: further sequences change neither the mask nor the locked fields.
- R12: Read data appears on `bus_rdata_o` at the clock edge that accepts the read, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pin_i | input | 16 | Pad input levels (asynchronous) |
| alt_val_i | input | 16 | Peripheral output value for alternate-function pins |
| pad_oe_o | output | 16 | Per-pin output enable |
| pad_do_o | output | 16 | Per-pin output value |
| pull_up_o | output | 16 | Per-pin pull-up enable |
| pull_dn_o | output | 16 | Per-pin pull-down enable |

## Verification
The bound checker watches, on every cycle, the properties that any single cycle can show. An open-drain pin never drives high, and the two pulls are never both on. Analog pins stay quiet. A set/clear write lands in the next cycle with set winning. Locked fields never change, and a completed lock never changes. The bench scenarios are what show the register layout at each word, the two-cycle input latency, the rejection of broken and reordered key sequences, and the fact that the mask is frozen after a lock. It runs seeded random configuration traffic against a bench model of the registers and pads, and compares every read and every pad output.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE   = 4'd0,
    REG_OTYPE  = 4'd1,
    REG_SPEED  = 4'd2,
    REG_PULL   = 4'd3,
    REG_IN     = 4'd4,
    REG_OUT    = 4'd5,
    REG_SETCLR = 4'd6,
    REG_LOCK   = 4'd7,
    REG_AF_LO  = 4'd8,
    REG_AF_HI  = 4'd9
  } reg_addr_e;

  typedef enum logic [1:0] {
    MD_IN  = 2'b00,
    MD_OUT = 2'b01,
    MD_ALT = 2'b10,
    MD_ANA = 2'b11
  } pin_mode_e;

  localparam logic [1:0] PL_UP = 2'b01;
  localparam logic [1:0] PL_DN = 2'b10;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_lock_fsm.sv
module gpio_lock_fsm #(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             we_i,
  input  logic             key_i,
  input  logic [NPINS-1:0] mask_i,
  output logic [NPINS-1:0] lock_o,
  output logic             done_o
);
  typedef enum logic [2:0] {LK_IDLE, LK_K1, LK_K0, LK_K1B, LK_RD1} lk_state_e;

  lk_state_e        st_q;
  logic [NPINS-1:0] mask_q, lock_q;
  logic             done_q;
  logic             same_mask;

  assign same_mask = (mask_i == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= LK_IDLE;
      mask_q <= '0;
      lock_q <= '0;
      done_q <= 1'b0;
    end else if (acc_i && !done_q) begin
      st_q <= LK_IDLE;  // any mismatch restarts
      case (st_q)
        LK_IDLE: if (we_i && key_i) begin
          st_q   <= LK_K1;
          mask_q <= mask_i;
        end
        LK_K1:  if (we_i && !key_i && same_mask) st_q <= LK_K0;
        LK_K0:  if (we_i && key_i && same_mask)  st_q <= LK_K1B;
        LK_K1B: if (!we_i) st_q <= LK_RD1;
        LK_RD1: if (!we_i) begin
          lock_q <= mask_q;
          done_q <= 1'b1;
        end
        default: st_q <= LK_IDLE;
      endcase
    end
  end

  assign lock_o = lock_q;
  assign done_o = done_q;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic [2*NPINS-1:0] mode_i,
  input  logic [NPINS-1:0]   otype_i,
  input  logic [2*NPINS-1:0] pull_i,
  input  logic [NPINS-1:0]   out_i,
  input  logic [NPINS-1:0]   alt_i,
  output logic [NPINS-1:0]   oe_o,
  output logic [NPINS-1:0]   do_o,
  output logic [NPINS-1:0]   pu_o,
  output logic [NPINS-1:0]   pd_o,
  output logic [NPINS-1:0]   ana_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_mode_e md;
    logic      drv, val;

    assign md = pin_mode_e'(mode_i[2*p +: 2]);

    always_comb begin
      drv = (md == MD_OUT) || (md == MD_ALT);
      val = (md == MD_ALT) ? alt_i[p] : out_i[p];
    end

    // open-drain: drive low only, release for 1
    assign oe_o[p]  = drv & (~otype_i[p] | ~val);
    assign do_o[p]  = drv & ~otype_i[p] & val;
    assign ana_o[p] = (md == MD_ANA);
    assign pu_o[p]  = (md != MD_ANA) && (pull_i[2*p +: 2] == PL_UP);
    assign pd_o[p]  = (md != MD_ANA) && (pull_i[2*p +: 2] == PL_DN);
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [NPINS-1:0]  alt_val_i,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic [NPINS-1:0]  pad_do_o,
  output logic [NPINS-1:0]  pull_up_o,
  output logic [NPINS-1:0]  pull_dn_o
);
  localparam int unsigned MW      = 2 * NPINS;
  localparam int unsigned AFW     = 4 * NPINS;
  localparam int unsigned AF_HI_W = AFW - BUS_W;

  logic [MW-1:0]    mode_q, speed_q, pull_q, lk2;
  logic [AFW-1:0]   af_q, lk4;
  logic [NPINS-1:0] otype_q, out_q, lock_q, ana, in_sync;
  logic             lock_done;
  logic [BUS_W-1:0] rd_c, rd_q;
  logic             wr, rd;

  assign wr = bus_req_i & bus_we_i;
  assign rd = bus_req_i & ~bus_we_i;

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      lk2[2*p +: 2] = {2{lock_q[p]}};
      lk4[4*p +: 4] = {4{lock_q[p]}};
    end
  end

  gpio_lock_fsm #(.NPINS(NPINS)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (bus_req_i && (bus_addr_i == REG_LOCK)),
    .we_i   (bus_we_i),
    .key_i  (bus_wdata_i[NPINS]),
    .mask_i (bus_wdata_i[NPINS-1:0]),
    .lock_o (lock_q),
    .done_o (lock_done)
  );

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (in_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      af_q    <= '0;
      out_q   <= '0;
    end else if (wr) begin
      case (bus_addr_i)
        REG_MODE:   mode_q  <= (mode_q & lk2) | (bus_wdata_i[MW-1:0] & ~lk2);
        REG_OTYPE:  otype_q <= (otype_q & lock_q) | (bus_wdata_i[NPINS-1:0] & ~lock_q);
        REG_SPEED:  speed_q <= (speed_q & lk2) | (bus_wdata_i[MW-1:0] & ~lk2);
        REG_PULL:   pull_q  <= (pull_q & lk2) | (bus_wdata_i[MW-1:0] & ~lk2);
        REG_OUT:    out_q   <= bus_wdata_i[NPINS-1:0];
        REG_SETCLR: out_q   <= (out_q & ~bus_wdata_i[2*NPINS-1:NPINS]) | bus_wdata_i[NPINS-1:0];
        REG_AF_LO:  af_q[BUS_W-1:0] <= (af_q[BUS_W-1:0] & lk4[BUS_W-1:0])
                                     | (bus_wdata_i & ~lk4[BUS_W-1:0]);
        REG_AF_HI:  af_q[AFW-1:BUS_W] <= (af_q[AFW-1:BUS_W] & lk4[AFW-1:BUS_W])
                                       | (bus_wdata_i[AF_HI_W-1:0] & ~lk4[AFW-1:BUS_W]);
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_c = '0;
    case (bus_addr_i)
      REG_MODE:  rd_c[MW-1:0]    = mode_q;
      REG_OTYPE: rd_c[NPINS-1:0] = otype_q;
      REG_SPEED: rd_c[MW-1:0]    = speed_q;
      REG_PULL:  rd_c[MW-1:0]    = pull_q;
      REG_IN:    rd_c[NPINS-1:0] = in_sync & ~ana;
      REG_OUT:   rd_c[NPINS-1:0] = out_q;
      REG_LOCK: begin
        rd_c[NPINS-1:0] = lock_q;
        rd_c[NPINS]     = lock_done;
      end
      REG_AF_LO: rd_c = af_q[BUS_W-1:0];
      REG_AF_HI: rd_c[AF_HI_W-1:0] = af_q[AFW-1:BUS_W];
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rd_q <= '0;
    else if (rd)  rd_q <= rd_c;
  end

  assign bus_rdata_o = rd_q;

  gpio_pad_ctrl #(.NPINS(NPINS)) u_pad (
    .mode_i  (mode_q),
    .otype_i (otype_q),
    .pull_i  (pull_q),
    .out_i   (out_q),
    .alt_i   (alt_val_i),
    .oe_o    (pad_oe_o),
    .do_o    (pad_do_o),
    .pu_o    (pull_up_o),
    .pd_o    (pull_dn_o),
    .ana_o   (ana)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [BUS_W-1:0]  bus_wdata_i,
  input logic [2*NPINS-1:0] mode_q,
  input logic [2*NPINS-1:0] speed_q,
  input logic [2*NPINS-1:0] pull_q,
  input logic [4*NPINS-1:0] af_q,
  input logic [NPINS-1:0]  otype_q,
  input logic [NPINS-1:0]  out_q,
  input logic [NPINS-1:0]  lock_q,
  input logic              lock_done,
  input logic [NPINS-1:0]  pad_oe_o,
  input logic [NPINS-1:0]  pad_do_o,
  input logic [NPINS-1:0]  pull_up_o,
  input logic [NPINS-1:0]  pull_dn_o
);
  logic [2*NPINS-1:0] c_lk2;
  logic [4*NPINS-1:0] c_lk4;
  logic [NPINS-1:0]   c_ana;
  logic               setclr_wr;

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      c_lk2[2*p +: 2] = {2{lock_q[p]}};
      c_lk4[4*p +: 4] = {4{lock_q[p]}};
      c_ana[p]        = (mode_q[2*p +: 2] == 2'b11);
    end
  end

  assign setclr_wr = bus_req_i && bus_we_i && (bus_addr_i == REG_SETCLR);

  assert_od_never_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & pad_do_o & otype_q) == '0);

  assert_pull_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_up_o & pull_dn_o) == '0);

  assert_analog_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o | pull_up_o | pull_dn_o) & c_ana) == '0);

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setclr_wr |=> ((out_q & $past(bus_wdata_i[NPINS-1:0])) == $past(bus_wdata_i[NPINS-1:0])));

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setclr_wr |=> ((out_q & $past(bus_wdata_i[2*NPINS-1:NPINS])
                    & ~$past(bus_wdata_i[NPINS-1:0])) == '0));

  assert_lock_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q ^ $past(mode_q)) & $past(c_lk2)) == '0);

  assert_lock_cfg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((speed_q ^ $past(speed_q)) | (pull_q ^ $past(pull_q))) & $past(c_lk2)) == '0);

  assert_lock_type_af_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((otype_q ^ $past(otype_q)) & $past(lock_q)) == '0) &&
    (((af_q ^ $past(af_q)) & $past(c_lk4)) == '0));

  assert_lock_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_done |=> ($stable(lock_q) && lock_done));
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .mode_q      (mode_q),
  .speed_q     (speed_q),
  .pull_q      (pull_q),
  .af_q        (af_q),
  .otype_q     (otype_q),
  .out_q       (out_q),
  .lock_q      (lock_q),
  .lock_done   (lock_done),
  .pad_oe_o    (pad_oe_o),
  .pad_do_o    (pad_do_o),
  .pull_up_o   (pull_up_o),
  .pull_dn_o   (pull_dn_o)
);

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] pins = '0, alt = '0;
  logic [N-1:0] oe, dout, pu, pd;

  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_port #(.NPINS(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pins), .alt_val_i(alt), .pad_oe_o(oe), .pad_do_o(dout),
    .pull_up_o(pu), .pull_dn_o(pd)
  );

  // bench model
  logic [31:0] m_mode, m_speed, m_pull;
  logic [63:0] m_af;
  logic [N-1:0] m_ot, m_out, m_lock;
  logic        m_done;

  task automatic model_reset();
    m_mode = '0; m_speed = '0; m_pull = '0; m_af = '0;
    m_ot = '0; m_out = '0; m_lock = '0; m_done = 1'b0;
  endtask

  function automatic logic [31:0] f_lk2();
    logic [31:0] r;
    for (int p = 0; p < N; p++) r[2*p +: 2] = {2{m_lock[p]}};
    return r;
  endfunction

  function automatic logic [63:0] f_lk4();
    logic [63:0] r;
    for (int p = 0; p < N; p++) r[4*p +: 4] = {4{m_lock[p]}};
    return r;
  endfunction

  function automatic logic [N-1:0] f_ana();
    logic [N-1:0] r;
    for (int p = 0; p < N; p++) r[p] = (m_mode[2*p +: 2] == 2'b11);
    return r;
  endfunction

  task automatic m_write(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] l2;
    logic [63:0] l4;
    l2 = f_lk2(); l4 = f_lk4();
    case (a)
      4'd0: m_mode  = (m_mode & l2) | (d & ~l2);
      4'd1: m_ot    = (m_ot & m_lock) | (d[15:0] & ~m_lock);
      4'd2: m_speed = (m_speed & l2) | (d & ~l2);
      4'd3: m_pull  = (m_pull & l2) | (d & ~l2);
      4'd5: m_out   = d[15:0];
      4'd6: m_out   = (m_out & ~d[31:16]) | d[15:0];
      4'd8: m_af[31:0]  = (m_af[31:0] & l4[31:0]) | (d & ~l4[31:0]);
      4'd9: m_af[63:32] = (m_af[63:32] & l4[63:32]) | (d & ~l4[63:32]);
      default: ;
    endcase
  endtask

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd0: return m_mode;
      4'd1: return {16'h0, m_ot};
      4'd2: return m_speed;
      4'd3: return m_pull;
      4'd4: return {16'h0, pins & ~f_ana()};
      4'd5: return {16'h0, m_out};
      4'd7: return {15'h0, m_done, m_lock};
      4'd8: return m_af[31:0];
      4'd9: return m_af[63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd4: return "R7 input word";
      4'd5: return "R6 output word";
      4'd6: return "R5 set/clear word";
      4'd7: return "R9 lock word";
      default: return "R8 config word";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic rd_check(input logic [3:0] a, input string tag);
    logic [31:0] e;
    e = exp_rd(a);
    bus_rd(a);
    check(tag, rdata, e);
  endtask

  task automatic wr_model(input logic [3:0] a, input logic [31:0] d);
    bus_wr(a, d);
    m_write(a, d);
  endtask

  task automatic pad_check(input string tag);
    logic [N-1:0] eoe, edo, epu, epd;
    for (int p = 0; p < N; p++) begin
      logic [1:0] md;
      logic drv, val;
      md  = m_mode[2*p +: 2];
      drv = (md == 2'b01) || (md == 2'b10);
      val = (md == 2'b10) ? alt[p] : m_out[p];
      eoe[p] = drv & (~m_ot[p] | ~val);
      edo[p] = drv & ~m_ot[p] & val;
      epu[p] = (md != 2'b11) && (m_pull[2*p +: 2] == 2'b01);
      epd[p] = (md != 2'b11) && (m_pull[2*p +: 2] == 2'b10);
    end
    check({tag, " R2 R3 oe"}, {16'h0, oe},   {16'h0, eoe});
    check({tag, " R2 R3 do"}, {16'h0, dout}, {16'h0, edo});
    check({tag, " R4 pu"},    {16'h0, pu},   {16'h0, epu});
    check({tag, " R4 pd"},    {16'h0, pd},   {16'h0, epd});
  endtask

  localparam logic [3:0] WR_ADDRS [9] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9};

  task automatic random_phase(input int iters);
    for (int it = 0; it < iters; it++) begin
      int unsigned r;
      r = $urandom % 10;
      if (r < 2) begin
        pins = N'($urandom); alt = N'($urandom);
        repeat (3) @(negedge clk);
        pad_check("rand pins");
        rd_check(4'd4, "R7 input word after pin change");
      end else if (r < 6) begin
        logic [3:0] a;
        a = WR_ADDRS[$urandom % 9];
        wr_model(a, $urandom);
        pad_check("rand write");
      end else begin
        logic [3:0] a;
        a = 4'($urandom % 10);
        rd_check(a, tag_of(a));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog: actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'hC0FFEE11));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 10; a++) rd_check(4'(a), "R1 reset read");
    pad_check("R1 reset pads");

    // R2/R3/R4 directed: pin0 out PP, pin1 alt, pin2 analog, pin3 out OD
    wr_model(4'd0, 32'h0000_0079);
    wr_model(4'd1, 32'h0000_0008);
    wr_model(4'd3, 32'h0000_3910);
    alt = 16'h0002;
    wr_model(4'd5, 32'h0000_0001);
    pad_check("R2 directed modes");
    alt = 16'h0000;
    @(negedge clk);
    pad_check("R2 alt value low");

    // R5 both set and clear on pin3: set wins -> open-drain released
    wr_model(4'd6, 32'h0008_0008);
    rd_check(4'd5, "R5 set wins over clear");
    pad_check("R3 open-drain released");
    wr_model(4'd6, 32'h0008_0000);
    rd_check(4'd5, "R5 clear pin3");
    pad_check("R3 open-drain low");
    rd_check(4'd6, "R5 set/clear reads zero");

    // R7 input with analog pin masked, write ignored
    pins = 16'hFFFF;
    repeat (3) @(negedge clk);
    rd_check(4'd4, "R7 analog pin reads 0");
    bus_wr(4'd4, 32'h0000_0000);
    rd_check(4'd4, "R7 write to input ignored");

    // R12 read data holds across a write
    bus_rd(4'd5);
    held = rdata;
    bus_wr(4'd5, 32'h0000_A5A5); m_write(4'd5, 32'h0000_A5A5);
    check("R12 read data holds", rdata, held);
    rd_check(4'd5, "R12 new read after write");

    random_phase(250);

    // R10 broken sequence: read where write due, then lone write + reads
    bus_wr(4'd7, 32'h0001_00F0);
    bus_wr(4'd7, 32'h0000_00F0);
    bus_rd(4'd7);
    bus_wr(4'd7, 32'h0000_00F0);
    bus_wr(4'd7, 32'h0001_00F0);
    bus_rd(4'd7);
    bus_rd(4'd7);
    rd_check(4'd7, "R10 broken sequence no lock");
    // R10 changed mask breaks
    bus_wr(4'd7, 32'h0001_00F0);
    bus_wr(4'd7, 32'h0000_00F1);
    bus_wr(4'd7, 32'h0001_00F0);
    bus_rd(4'd7);
    bus_rd(4'd7);
    rd_check(4'd7, "R10 mask change no lock");
    wr_model(4'd0, 32'hFFFF_FFFF);
    rd_check(4'd0, "R10 mode still writable");

    // R9 good sequence with other traffic in between (R10)
    bus_wr(4'd7, 32'h0001_00F0);
    wr_model(4'd5, 32'h0000_1234);
    bus_wr(4'd7, 32'h0000_00F0);
    rd_check(4'd3, "R10 interleaved read");
    bus_wr(4'd7, 32'h0001_00F0);
    bus_rd(4'd7);
    bus_rd(4'd7);
    m_lock = 16'h00F0; m_done = 1'b1;
    rd_check(4'd7, "R9 lock word after sequence");
    wr_model(4'd0, 32'h0000_0000);
    rd_check(4'd0, "R9 locked mode fields hold");
    wr_model(4'd8, 32'h0000_0000);
    rd_check(4'd8, "R9 locked selector fields hold");
    wr_model(4'd1, 32'h0000_FFFF);
    rd_check(4'd1, "R9 locked type bits hold");

    // R11 second sequence has no effect
    bus_wr(4'd7, 32'h0001_FFFF);
    bus_wr(4'd7, 32'h0000_FFFF);
    bus_wr(4'd7, 32'h0001_FFFF);
    bus_rd(4'd7);
    bus_rd(4'd7);
    rd_check(4'd7, "R11 lock frozen");
    wr_model(4'd3, 32'h5555_5555);
    rd_check(4'd3, "R11 unlocked pins still writable");

    random_phase(250);

    // R1 reset clears the lock
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    rd_check(4'd7, "R1 reset clears lock");
    wr_model(4'd0, 32'h0000_FF00);
    rd_check(4'd0, "R1 mode writable after reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule